// File: doc/BRIEF.md
# Prescaled Reference Timer

This block is a 16-bit interval timer for a peripheral bus. A programmable prescaler divides the system clock, and an optional extra divide-by-16 stage can follow it. Each prescaled tick advances a counter. When the counter has reached the programmed reference value, the next tick returns it to zero and sets a sticky reference event flag. That flag, gated by an enable bit in the mode register, drives a level interrupt.

Software controls the timer through a small synchronous register bus. Any cycle with `bus_en` and `bus_we` high is a write. Read data is presented combinationally for whatever offset is on `bus_addr`. A typical driver does three things in order: it writes the reference value, writes the mode register with the enable bit set, and then clears the event flag by writing 1 to it from its interrupt handler.

Top module: `ref_match_timer`

## Requirements
- R1: After reset the mode, reference, capture, counter and event registers all read 0, and `irq_o` is 0.
- R2: The counter advances by one on every prescaled tick. The tick period in clock cycles is (mode[15:8]+1) when source code mode[2:1] is 1, and (mode[15:8]+1)*16 when the source code is 2.
- R3: The counter holds its value, and no tick takes effect, under either of two conditions: the source code mode[2:1] is 0 or 3, or the restart-on-reference bit mode[3] is 0.
- R4: When the count equals a nonzero reference value, the next tick sets the count to 0. On that same clock edge the tick also sets the reference flag, which is bit 1 of the event register.
- R5: With a reference value of 0, the reference flag is never set, and the counter keeps counting upward with 16-bit wrap.
- R6: In the event register, bit 0 is the capture flag and bit 1 is the reference flag. A write sets to 0 each bit that has a 1 in the write data. Bits written as 0 keep their value. A hardware set on the same edge wins over the clear.
- R7: `irq_o` is high exactly while mode bit 4 (reference interrupt enable) and the reference flag are both 1.
- R8: A mode write that changes the enable bit mode[0] from 1 to 0 clears both the mode and reference registers. While mode[0] is 0, the counter and prescaler are held at 0 and count writes have no effect.
- R9: A write to the mode register or the reference register sets the prescaler and counter to 0 on that clock edge. Counting then resumes with the new settings.
- R10: A write to offset 0xC loads the write data into the counter. When the counter is enabled, it continues counting from that value.
- R11: Offsets: mode 0x00, reference 0x04, capture 0x08 (plain read/write storage), counter 0x0C, event 0x11 (read zero-extended). All other offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Reference interrupt, level |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit prescale field and a 4-bit divide-by-16 stage. Prescale values of 0, 1 and 2 keep every tick period short. Within a few dozen cycles the bench can therefore reach three cases: the single-cycle tick, the three-cycle prescaled tick, and the divide-by-16 path at a 32-cycle period. A 300-cycle run with a zero reference shows that the counter passes through values well beyond any reference used elsewhere, and that no event is produced.

// File: rtl/tmr_pkg.sv
// Package: shared register offsets and mode-field positions for the
// prescaled reference timer. Assumes byte offsets on an 8-bit address.
package tmr_pkg;

    localparam int OFS_MODE = 'h00;
    localparam int OFS_REF  = 'h04;
    localparam int OFS_CAP  = 'h08;
    localparam int OFS_CNT  = 'h0C;
    localparam int OFS_EVT  = 'h11;

    localparam int MB_EN       = 0;
    localparam int MB_SRC_LO   = 1;
    localparam int MB_RESTART  = 3;
    localparam int MB_IE       = 4;
    localparam int MB_PRE_LSB  = 8;

    localparam int EB_CAP = 0;
    localparam int EB_REF = 1;
    localparam int EVT_W  = 2;

    typedef enum logic [1:0] {
        SRC_OFF0  = 2'd0,
        SRC_SYS   = 2'd1,
        SRC_SYS16 = 2'd2,
        SRC_OFF3  = 2'd3
    } src_sel_e;

endpackage

// File: rtl/tmr_regs.sv
// Module: register file and bus decoder for the timer.
// Holds mode, reference, capture and event registers, produces restart
// and load strobes, and muxes read data. Assumes DATA_W >= CNT_W and
// that writes complete in a single cycle.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              match_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] mode_o,
    output logic [CNT_W-1:0]  ref_o,
    output logic [EVT_W-1:0]  evt_o,
    output logic              restart_o,
    output logic              load_o
);

    logic              wr;
    logic              wr_mode, wr_ref, wr_cap, wr_cnt, wr_evt;
    logic              disarm;
    logic [DATA_W-1:0] mode_q;
    logic [CNT_W-1:0]  ref_q;
    logic [DATA_W-1:0] cap_q;
    logic [EVT_W-1:0]  evt_q;
    logic [EVT_W-1:0]  evt_clr;
    logic [EVT_W-1:0]  evt_set;

    // Address decode of the single-cycle write strobe.
    always_comb begin
        wr      = bus_en && bus_we;
        wr_mode = wr && (bus_addr == ADDR_W'(OFS_MODE));
        wr_ref  = wr && (bus_addr == ADDR_W'(OFS_REF));
        wr_cap  = wr && (bus_addr == ADDR_W'(OFS_CAP));
        wr_cnt  = wr && (bus_addr == ADDR_W'(OFS_CNT));
        wr_evt  = wr && (bus_addr == ADDR_W'(OFS_EVT));
        disarm  = wr_mode && mode_q[MB_EN] && !bus_wdata[MB_EN];
    end

    // Mode register; falling enable wipes the whole register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (disarm)
            mode_q <= '0;
        else if (wr_mode)
            mode_q <= bus_wdata;
    end

    // Reference register; also wiped by a falling enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= '0;
        else if (disarm)
            ref_q <= '0;
        else if (wr_ref)
            ref_q <= CNT_W'(bus_wdata);
    end

    // Capture register: plain storage, no pin capture logic.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else if (wr_cap)
            cap_q <= bus_wdata;
    end

    // Event flag set/clear terms; hardware set wins over write-1-to-clear.
    always_comb begin
        evt_clr         = wr_evt ? bus_wdata[EVT_W-1:0] : '0;
        evt_set         = '0;
        evt_set[EB_REF] = match_i;
    end

    // Event register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= '0;
        else
            evt_q <= (evt_q & ~evt_clr) | evt_set;
    end

    // Read data multiplexer; unmapped offsets return zero.
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_MODE): rdata_o = mode_q;
            ADDR_W'(OFS_REF):  rdata_o = DATA_W'(ref_q);
            ADDR_W'(OFS_CAP):  rdata_o = cap_q;
            ADDR_W'(OFS_CNT):  rdata_o = DATA_W'(cnt_i);
            ADDR_W'(OFS_EVT):  rdata_o = DATA_W'(evt_q);
            default:           rdata_o = '0;
        endcase
    end

    assign mode_o    = mode_q;
    assign ref_o     = ref_q;
    assign evt_o     = evt_q;
    assign restart_o = wr_mode || wr_ref;
    assign load_o    = wr_cnt;

endmodule

// File: rtl/tmr_prescaler.sv
// Module: clock prescaler. Emits a one-cycle tick every (pre_val+1)
// cycles, or every (pre_val+1)*2**SUB_W cycles when use_sub is set.
// Assumes restart and !run both return all stages to zero.
module tmr_prescaler #(
    parameter int PRE_W = 8,
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_val,
    input  logic             use_sub,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;
    logic             pre_wrap;

    // First stage wrap detect.
    assign pre_wrap = run && (pre_q == pre_val);

    // First stage counter: 0 .. pre_val.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run)
            pre_q <= '0;
        else if (pre_wrap)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    generate
        if (SUB_W > 0) begin : g_sub
            logic [SUB_W-1:0] sub_q;

            // Second stage: counts first-stage wraps when selected.
            always_ff @(posedge clk) begin
                if (!rst_n || restart || !run || !use_sub)
                    sub_q <= '0;
                else if (pre_wrap)
                    sub_q <= sub_q + 1'b1;
            end

            // Tick on the last wrap of the second stage, or every wrap.
            assign tick = pre_wrap && (!use_sub || (&sub_q));
        end else begin : g_nosub
            // No second stage configured: every wrap is a tick.
            assign tick = pre_wrap;
        end
    endgenerate

endmodule

// File: rtl/tmr_counter.sv
// Module: reference-restart counter. Advances on ticks, returns to zero
// on the tick after reaching a nonzero reference, and reports that
// event. Assumes load and restart are single-cycle strobes.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] ref_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    // Reference hit on a tick that is not overridden by a bus strobe.
    assign hit = en && run && tick && !restart && !load &&
                 (ref_val != '0) && (cnt_q == ref_val);

    // Count register with priority: disable, restart, load, tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && tick)
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end

    assign cnt_o   = cnt_q;
    assign match_o = hit;

endmodule

// File: rtl/ref_match_timer.sv
// Module: top of the prescaled reference timer. Decodes mode fields,
// connects the register file, prescaler and counter, and forms the
// interrupt. Assumes a synchronous single-cycle register bus.
module ref_match_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int SUB_W  = 4,
    localparam int DATA_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    logic [DATA_W-1:0] mode_q;
    logic [CNT_W-1:0]  ref_q;
    logic [EVT_W-1:0]  evt_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              restart, load, tick, match, run, mode_en;
    src_sel_e          src;
    logic [PRE_W-1:0]  pre_val;

    // Mode field decode and run qualification.
    always_comb begin
        mode_en = mode_q[MB_EN];
        src     = src_sel_e'(mode_q[MB_SRC_LO +: 2]);
        pre_val = mode_q[MB_PRE_LSB +: PRE_W];
        run     = mode_en && mode_q[MB_RESTART] &&
                  ((src == SRC_SYS) || (src == SRC_SYS16));
    end

    tmr_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_i     (cnt_q),
        .match_i   (match),
        .rdata_o   (bus_rdata),
        .mode_o    (mode_q),
        .ref_o     (ref_q),
        .evt_o     (evt_q),
        .restart_o (restart),
        .load_o    (load)
    );

    tmr_prescaler #(
        .PRE_W (PRE_W),
        .SUB_W (SUB_W)
    ) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .pre_val (pre_val),
        .use_sub (src == SRC_SYS16),
        .tick    (tick)
    );

    tmr_counter #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mode_en),
        .run      (run),
        .tick     (tick),
        .restart  (restart),
        .load     (load),
        .load_val (CNT_W'(bus_wdata)),
        .ref_val  (ref_q),
        .cnt_o    (cnt_q),
        .match_o  (match)
    );

    // Level interrupt from the sticky reference flag.
    assign irq_o = mode_q[MB_IE] && evt_q[EB_REF];

endmodule

// File: rtl/tmr_chk.sv
// Checker: temporal properties of the reference timer, bound to the top.
module tmr_chk #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] mode_q,
    input logic [CNT_W-1:0]  ref_q,
    input logic [1:0]        evt_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              tick,
    input logic              run,
    input logic              load,
    input logic              restart,
    input logic              irq_o
);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && !$past(restart) && (cnt_q != $past(cnt_q)))
        |-> ((cnt_q == '0) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)))); // R2

    AST_UNSUP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[0] && !run && !load && !restart) |=> $stable(cnt_q)); // R3

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && !restart && (ref_q != '0) && (cnt_q == ref_q))
        |=> (evt_q[1] && (cnt_q == '0))); // R4

    AST_ZERO_REF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q[1]) |-> ($past(ref_q) != '0)); // R5

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($rose(evt_q[1]) || $rose(mode_q[4]))); // R7

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[0] |=> (cnt_q == '0)); // R8

endmodule

bind ref_match_timer tmr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_q  (mode_q),
    .ref_q   (ref_q),
    .evt_q   (evt_q),
    .cnt_q   (cnt_q),
    .tick    (tick),
    .run     (run),
    .load    (load),
    .restart (restart),
    .irq_o   (irq_o)
);

// File: tb/test_ref_match_timer.sv
// Directed bench for the prescaled reference timer.
module test_ref_match_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    ref_match_timer i_ref_match_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_reg(input string tag, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(tag, {16'd0, v}, {16'd0, exp});
    endtask

    // Disable, program reference, clear events, then arm mode.
    task automatic start(input logic [15:0] refv, input logic [15:0] modev);
        wr(8'h00, 16'h0000);
        wr(8'h04, refv);
        wr(8'h11, 16'h0003);
        wr(8'h00, modev);
    endtask

    task automatic t_reset;
        chk_reg("R1 mode", 8'h00, 16'h0);
        chk_reg("R1 ref", 8'h04, 16'h0);
        chk_reg("R1 cap", 8'h08, 16'h0);
        chk_reg("R1 cnt", 8'h0C, 16'h0);
        chk_reg("R1 evt", 8'h11, 16'h0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_basic;
        start(16'd5, 16'h001B);
        step(3);
        chk_reg("R2 cnt@3", 8'h0C, 16'd3);
        step(2);
        chk_reg("R4 cnt@5", 8'h0C, 16'd5);
        chk_reg("R4 evt@5", 8'h11, 16'h0);
        chk("R7 irq low@5", {31'd0, irq_o}, 32'd0);
        step(1);
        chk_reg("R4 wrap cnt", 8'h0C, 16'd0);
        chk_reg("R4 flag", 8'h11, 16'h2);
        chk("R7 irq high", {31'd0, irq_o}, 32'd1);
        wr(8'h11, 16'h0001);
        chk_reg("R6 clear other bit", 8'h11, 16'h2);
        wr(8'h11, 16'h0002);
        chk_reg("R6 cleared", 8'h11, 16'h0);
        chk("R7 irq after clear", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_irq_gate;
        start(16'd3, 16'h000B);
        step(4);
        chk_reg("R4 flag ie off", 8'h11, 16'h2);
        chk("R7 irq masked", {31'd0, irq_o}, 32'd0);
        wr(8'h00, 16'h001B);
        chk("R7 irq on enable", {31'd0, irq_o}, 32'd1);
    endtask

    task automatic t_prescale;
        start(16'd2, 16'h020B);
        step(5);
        chk_reg("R2 pre3 cnt@5", 8'h0C, 16'd1);
        step(3);
        chk_reg("R2 pre3 cnt@8", 8'h0C, 16'd2);
        chk_reg("R4 pre3 evt@8", 8'h11, 16'h0);
        step(1);
        chk_reg("R4 pre3 wrap", 8'h0C, 16'd0);
        chk_reg("R4 pre3 flag", 8'h11, 16'h2);
    endtask

    task automatic t_div16;
        start(16'd1, 16'h010D);
        step(31);
        chk_reg("R2 div16 cnt@31", 8'h0C, 16'd0);
        step(1);
        chk_reg("R2 div16 cnt@32", 8'h0C, 16'd1);
        step(31);
        chk_reg("R2 div16 evt@63", 8'h11, 16'h0);
        step(1);
        chk_reg("R4 div16 wrap", 8'h0C, 16'd0);
        chk_reg("R4 div16 flag", 8'h11, 16'h2);
    endtask

    task automatic t_unsupported;
        logic [15:0] modes [3] = '{16'h0009, 16'h000F, 16'h0003};
        for (int i = 0; i < 3; i++) begin
            start(16'd2, modes[i]);
            step(10);
            chk_reg("R3 held cnt", 8'h0C, 16'd0);
            chk_reg("R3 no event", 8'h11, 16'h0);
        end
    endtask

    task automatic t_disable;
        start(16'd10, 16'h001B);
        step(4);
        chk_reg("R8 running", 8'h0C, 16'd4);
        wr(8'h00, 16'h1230);
        chk_reg("R8 mode cleared", 8'h00, 16'h0);
        chk_reg("R8 ref cleared", 8'h04, 16'h0);
        step(5);
        chk_reg("R8 cnt held", 8'h0C, 16'd0);
        wr(8'h0C, 16'd7);
        chk_reg("R8 load ignored", 8'h0C, 16'd0);
    endtask

    task automatic t_restart;
        start(16'd10, 16'h000B);
        step(4);
        chk_reg("R9 pre", 8'h0C, 16'd4);
        wr(8'h04, 16'd10);
        chk_reg("R9 ref write restart", 8'h0C, 16'd0);
        step(2);
        chk_reg("R9 resumes", 8'h0C, 16'd2);
        wr(8'h00, 16'h000B);
        chk_reg("R9 mode write restart", 8'h0C, 16'd0);
    endtask

    task automatic t_load;
        start(16'd100, 16'h000B);
        step(2);
        wr(8'h0C, 16'd40);
        chk_reg("R10 loaded", 8'h0C, 16'd40);
        step(3);
        chk_reg("R10 continues", 8'h0C, 16'd43);
        wr(8'h0C, 16'd100);
        step(1);
        chk_reg("R10 load at ref wraps", 8'h0C, 16'd0);
        chk_reg("R10 load at ref flags", 8'h11, 16'h2);
    endtask

    task automatic t_zero_ref;
        start(16'd0, 16'h001B);
        step(300);
        chk_reg("R5 counts past", 8'h0C, 16'd300);
        chk_reg("R5 no event", 8'h11, 16'h0);
        chk("R5 no irq", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_map;
        logic [15:0] m0;
        rd(8'h00, m0);
        wr(8'h08, 16'hBEEF);
        chk_reg("R11 cap rw", 8'h08, 16'hBEEF);
        wr(8'h10, 16'hFFFF);
        wr(8'h02, 16'hFFFF);
        chk_reg("R11 unmapped 0x10", 8'h10, 16'h0);
        chk_reg("R11 unmapped 0x02", 8'h02, 16'h0);
        chk_reg("R11 cap kept", 8'h08, 16'hBEEF);
        chk_reg("R11 mode kept", 8'h00, m0);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_basic();
        t_irq_gate();
        t_prescale();
        t_div16();
        t_unsupported();
        t_disable();
        t_restart();
        t_load();
        t_zero_ref();
        t_map();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule